// File: doc/BRIEF.md
# Temperature-Adjusted LED Fuel Display

This block turns a battery's available-capacity count into a five-segment bar graph. The bar shows remaining charge as a share of the learned full capacity. Before that share is banded, it is derated by a factor that depends on the cell chemistry and the pack temperature. The stored capacity count itself is never changed; the derating affects only what is shown.

The bar is dark unless something wakes it. A press on an active-low push-button lights it for a window of about four seconds, and a new press restarts that window. The bar also stays lit while the capacity counters report charge or discharge activity above the 2 mV sense-voltage equivalent. When capacity is nearly gone, or the pack voltage is at or below the empty threshold, only the lowest segment shows, and it blinks at 4 Hz.

Two controls sit above the bar logic. A manual override word can drive the segments directly. A calibration-busy input blanks every segment while the sense-offset calibration runs. Blink and timeout timing come from a prescaler set by the system clock frequency parameter.

Top module: `fuel_gauge_display`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `led` is 5'b00000; the wake window is closed and the blink phase is 0.
- R2: With A = `avail_cap` × factor and F = `full_cap` × 100, a lit, non-blinking display shows a thermometer from `led[0]` upward: 5'b11111 for A ≥ 0.80F, 5'b01111 for A ≥ 0.60F, 5'b00111 for A ≥ 0.40F, 5'b00011 for A ≥ 0.20F, and 5'b00001 for A ≥ 0.06F.
- R3: When a lit display has A < 0.06F, or when `low_volt` is 1, `led[4:1]` is 0 and `led[0]` follows a blink phase that toggles every CLK_HZ/8 cycles (4 Hz blink).
- R4: While `button_n` is 0 the wake window is reloaded to 32 eighth-second ticks. Each tick then takes one count off, and the display stays lit until the count reaches zero. A new press restarts the full window.
- R5: While `chg_active` or `dsg_active` is 1 the display is lit. With both at 0 and the wake window closed, `led` is 0.
- R6: For NiCd (`chem_nimh` = 0) the factor is 100 % for `temp_c` ≥ 0, 90 % for −10 ≤ `temp_c` < 0, 75 % for −20 ≤ `temp_c` < −10, and 50 % below −20 (signed °C).
- R7: For NiMH (`chem_nimh` = 1) the factor is 100 % for `temp_c` ≥ 10, 75 % for 0 ≤ `temp_c` < 10, 40 % for −10 ≤ `temp_c` < 0, and 0 % below −10.
- R8: When `ovr_ctrl[5]` is 0 and calibration is idle, `led` equals `ovr_ctrl[4:0]` (1 lights the segment), whether or not the display is awake.
- R9: While `cal_busy` is 1, `led` is 0 regardless of every other input.
- R10: `led` is registered: a change on any input shows on `led` after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| avail_cap | input | CAP_W | Available capacity count |
| full_cap | input | CAP_W | Learned full capacity count |
| chem_nimh | input | 1 | Chemistry select: 0 NiCd, 1 NiMH |
| temp_c | input | 8 | Signed pack temperature in °C |
| low_volt | input | 1 | Pack voltage at or below the empty threshold |
| button_n | input | 1 | Active-low push-button |
| chg_active | input | 1 | Charge activity above the 2 mV equivalent |
| dsg_active | input | 1 | Discharge activity above the 2 mV equivalent |
| ovr_ctrl | input | 6 | Bit 5: 0 selects manual; bits 4:0: manual segment pattern |
| cal_busy | input | 1 | Sense-offset calibration running |
| led | output | 5 | Segment drive, bit 0 is the lowest segment |

## Verification
Capacity ratios are set just above and just below each band edge (80, 60, 40, 20 and 6 %). This shows that every threshold compares the right products and is inclusive at its lower end. The same full pack is then shown at temperatures on both sides of each table edge, for both chemistries. Any segment change in those runs can only come from the factor lookup, which keeps derating faults apart from banding faults. Wake-up is tried three ways: by activity flags, by one button press allowed to expire, and by a second press that must extend the window. The override and calibration inputs are applied during activity and during idle, which exposes the order of priority among them.

// File: rtl/fgd_pkg.sv
package fgd_pkg;

    localparam int PCT_W   = 7;
    localparam int SEGS    = 5;
    localparam int LOW_PCT = 6;

    typedef struct packed {
        logic             manual_n;
        logic [SEGS-1:0]  seg;
    } ovr_t;

    typedef enum logic [1:0] {
        SHOW_DARK,
        SHOW_MANUAL,
        SHOW_BAR
    } show_e;

    function automatic logic [PCT_W-1:0] derate_pct(input logic nimh,
                                                    input logic signed [7:0] t);
        logic [PCT_W-1:0] p;
        if (!nimh) begin
            if (t >= 8'sd0)         p = 7'd100;
            else if (t >= -8'sd10)  p = 7'd90;
            else if (t >= -8'sd20)  p = 7'd75;
            else                    p = 7'd50;
        end else begin
            if (t >= 8'sd10)        p = 7'd100;
            else if (t >= 8'sd0)    p = 7'd75;
            else if (t >= -8'sd10)  p = 7'd40;
            else                    p = 7'd0;
        end
        return p;
    endfunction

    function automatic int band_edge_pct(input int idx);
        return 20 * (idx + 1);
    endfunction

endpackage

// File: rtl/fgd_tick.sv
module fgd_tick #(
    parameter int TICK_DIV = 4000
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic phase
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (tick) phase <= ~phase;
        end
    end
endmodule

// File: rtl/fgd_window.sv
module fgd_window #(
    parameter int WIN_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic button_n,
    output logic open
);
    localparam int WW = $clog2(WIN_TICKS + 1);

    logic [WW-1:0] left_q;

    assign open = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (!button_n) begin
            left_q <= WW'(WIN_TICKS);
        end else if (tick && open) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/fgd_bar.sv
module fgd_bar
    import fgd_pkg::*;
#(
    parameter int CAP_W = 16
) (
    input  logic [CAP_W-1:0]  avail_cap,
    input  logic [CAP_W-1:0]  full_cap,
    input  logic              chem_nimh,
    input  logic signed [7:0] temp_c,
    input  logic              low_volt,
    input  logic              phase,
    output logic [SEGS-1:0]   bar
);
    localparam int PROD_W = CAP_W + PCT_W;
    localparam int EDGES  = SEGS - 1;

    logic [PCT_W-1:0]  pct;
    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] low_thr;
    logic [EDGES-1:0]  above;
    logic              empty;

    assign pct     = derate_pct(chem_nimh, temp_c);
    assign scaled  = PROD_W'(avail_cap) * PROD_W'(pct);
    assign low_thr = PROD_W'(full_cap) * PROD_W'(LOW_PCT);
    assign empty   = low_volt || (scaled < low_thr);

    for (genvar i = 0; i < EDGES; i++) begin : g_edge
        localparam logic [PROD_W-1:0] K = PROD_W'(band_edge_pct(i));
        logic [PROD_W-1:0] thr;
        assign thr      = PROD_W'(full_cap) * K;
        assign above[i] = (scaled >= thr);
    end

    always_comb begin
        if (empty) bar = {{(SEGS-1){1'b0}}, phase};
        else       bar = {above, 1'b1};
    end
endmodule

// File: rtl/fuel_gauge_display.sv
module fuel_gauge_display
    import fgd_pkg::*;
#(
    parameter int CAP_W     = 16,
    parameter int CLK_HZ    = 32000,
    parameter int WIN_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CAP_W-1:0]  avail_cap,
    input  logic [CAP_W-1:0]  full_cap,
    input  logic              chem_nimh,
    input  logic signed [7:0] temp_c,
    input  logic              low_volt,
    input  logic              button_n,
    input  logic              chg_active,
    input  logic              dsg_active,
    input  logic [5:0]        ovr_ctrl,
    input  logic              cal_busy,
    output logic [4:0]        led
);
    localparam int TICK_DIV = CLK_HZ / 8;

    logic            tick;
    logic            phase;
    logic            win_open;
    logic            disp_en;
    logic [SEGS-1:0] bar;
    logic [SEGS-1:0] led_d;
    ovr_t            ovr;
    show_e           show;

    fgd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .phase (phase)
    );

    fgd_window #(.WIN_TICKS(WIN_TICKS)) u_window (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .button_n (button_n),
        .open     (win_open)
    );

    fgd_bar #(.CAP_W(CAP_W)) u_bar (
        .avail_cap (avail_cap),
        .full_cap  (full_cap),
        .chem_nimh (chem_nimh),
        .temp_c    (temp_c),
        .low_volt  (low_volt),
        .phase     (phase),
        .bar       (bar)
    );

    assign ovr     = ovr_t'(ovr_ctrl);
    assign disp_en = win_open || chg_active || dsg_active;

    always_comb begin
        if (cal_busy)          show = SHOW_DARK;
        else if (!ovr.manual_n) show = SHOW_MANUAL;
        else if (disp_en)      show = SHOW_BAR;
        else                   show = SHOW_DARK;
    end

    always_comb begin
        case (show)
            SHOW_MANUAL: led_d = ovr.seg;
            SHOW_BAR:    led_d = bar;
            default:     led_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) led <= '0;
        else     led <= led_d;
    end
endmodule

// File: rtl/fgd_checker.sv
module fgd_checker (
    input logic       clk,
    input logic       rst,
    input logic [5:0] ovr_ctrl,
    input logic       cal_busy,
    input logic       low_volt,
    input logic       disp_en,
    input logic [4:0] led
);
    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> (led == 5'd0)); // R1

    AST_CAL_DARK: assert property (@(posedge clk) disable iff (rst)
        cal_busy |=> (led == 5'd0)); // R9

    AST_MANUAL_PASS: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && !ovr_ctrl[5]) |=> (led == $past(ovr_ctrl[4:0]))); // R8

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && ovr_ctrl[5] && !disp_en) |=> (led == 5'd0)); // R5

    AST_BAR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && ovr_ctrl[5]) |=> ((led & (led + 5'd1)) == 5'd0)); // R2

    AST_LOWV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!cal_busy && ovr_ctrl[5] && low_volt) |=> (led[4:1] == 4'd0)); // R3
endmodule

bind fuel_gauge_display fgd_checker i_fgd_checker (
    .clk      (clk),
    .rst      (rst),
    .ovr_ctrl (ovr_ctrl),
    .cal_busy (cal_busy),
    .low_volt (low_volt),
    .disp_en  (disp_en),
    .led      (led)
);

// File: tb/test_fuel_gauge_display.sv
`timescale 1ns/1ps
module test_fuel_gauge_display;
    localparam int CLK_HZ = 64;
    localparam int DIV    = CLK_HZ / 8;
    localparam int WIN    = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       avail_cap = 16'd0;
    logic [15:0]       full_cap  = 16'd1000;
    logic              chem_nimh = 1'b0;
    logic signed [7:0] temp_c    = 8'sd25;
    logic              low_volt  = 1'b0;
    logic              button_n  = 1'b1;
    logic              chg_active = 1'b0;
    logic              dsg_active = 1'b0;
    logic [5:0]        ovr_ctrl  = 6'b100000;
    logic              cal_busy  = 1'b0;
    logic [4:0]        led;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fuel_gauge_display #(.CLK_HZ(CLK_HZ), .WIN_TICKS(WIN)) i_fuel_gauge_display (
        .clk(clk), .rst(rst), .avail_cap(avail_cap), .full_cap(full_cap),
        .chem_nimh(chem_nimh), .temp_c(temp_c), .low_volt(low_volt),
        .button_n(button_n), .chg_active(chg_active), .dsg_active(dsg_active),
        .ovr_ctrl(ovr_ctrl), .cal_busy(cal_busy), .led(led)
    );

    // Reference model: derating tables written from the requirements
    function automatic int factor(input bit nimh, input int t);
        if (!nimh) return (t >= 0) ? 100 : (t >= -10) ? 90 : (t >= -20) ? 75 : 50; // R6
        return (t >= 10) ? 100 : (t >= 0) ? 75 : (t >= -10) ? 40 : 0;          // R7
    endfunction

    int    m_cyc = 0;
    bit    m_phase = 0;
    int    m_left = 0;
    logic [4:0] m_exp = 5'd0;
    string m_tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_phase = 0; m_left = 0; m_exp = 5'd0; m_tag = "R1";
        end else begin
            longint a, f;
            a = longint'(avail_cap) * factor(chem_nimh, int'(temp_c));
            f = longint'(full_cap) * 100;
            if (cal_busy) begin
                m_exp = 5'd0; m_tag = "R9";
            end else if (!ovr_ctrl[5]) begin
                m_exp = ovr_ctrl[4:0]; m_tag = "R8";
            end else if (!(m_left > 0 || chg_active || dsg_active)) begin
                m_exp = 5'd0; m_tag = "R5";
            end else if (low_volt || a * 100 < f * 6) begin
                m_exp = {4'd0, m_phase}; m_tag = "R3";
            end else begin
                m_tag = "R2";
                if (a * 100 >= f * 80)      m_exp = 5'b11111;
                else if (a * 100 >= f * 60) m_exp = 5'b01111;
                else if (a * 100 >= f * 40) m_exp = 5'b00111;
                else if (a * 100 >= f * 20) m_exp = 5'b00011;
                else                        m_exp = 5'b00001;
            end
            begin
                bit tk;
                tk = (m_cyc % DIV) == DIV - 1;
                m_cyc++;
                if (tk) m_phase = ~m_phase;
                if (!button_n) m_left = WIN;
                else if (tk && m_left > 0) m_left--;
            end
        end
    end

    // Cycle-by-cycle comparison against the model (R10 latency included)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (led !== m_exp) begin
                fails++;
                $display("FAIL %s model: led=%b expected=%b at %0t", m_tag, led, m_exp, $time);
            end
        end
    end

    task automatic check(input string tag, input logic [4:0] exp);
        checks++;
        if (led !== exp) begin
            fails++;
            $display("FAIL %s: led=%b expected=%b at %0t", tag, led, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic blink_check(input string tag);
        int toggles = 0;
        logic prev;
        bit upper_ok = 1;
        @(negedge clk);
        prev = led[0];
        for (int k = 0; k < 2 * DIV; k++) begin
            @(negedge clk);
            if (led[0] !== prev) toggles++;
            if (led[4:1] !== 4'd0) upper_ok = 0;
            prev = led[0];
        end
        checks++;
        if (toggles != 2 || !upper_ok) begin
            fails++;
            $display("FAIL %s blink: toggles=%0d upper_ok=%0d expected toggles=2 upper_ok=1",
                     tag, toggles, upper_ok);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        check("R1", 5'd0);
        rst = 1'b0;
        wait_n(1);
        check("R1", 5'd0);
        wait_n(3);
        check("R5", 5'd0);

        // R2 banding at 100 % factor
        chg_active = 1;
        avail_cap = 16'd850;  wait_n(2); check("R2 85%", 5'b11111);
        avail_cap = 16'd800;  wait_n(2); check("R2 80%", 5'b11111);
        avail_cap = 16'd799;  wait_n(2); check("R2 79.9%", 5'b01111);
        avail_cap = 16'd600;  wait_n(2); check("R2 60%", 5'b01111);
        avail_cap = 16'd599;  wait_n(2); check("R2 59.9%", 5'b00111);
        avail_cap = 16'd400;  wait_n(2); check("R2 40%", 5'b00111);
        avail_cap = 16'd399;  wait_n(2); check("R2 39.9%", 5'b00011);
        avail_cap = 16'd200;  wait_n(2); check("R2 20%", 5'b00011);
        avail_cap = 16'd199;  wait_n(2); check("R2 19.9%", 5'b00001);
        avail_cap = 16'd60;   wait_n(2); check("R2 6%", 5'b00001);
        avail_cap = 16'd59;   blink_check("R3 below 6%");

        // R6 NiCd derating
        dsg_active = 1; chg_active = 0;
        avail_cap = 16'd1000;
        temp_c = 8'sd0;    wait_n(2); check("R6 0C", 5'b11111);
        temp_c = -8'sd5;   wait_n(2); check("R6 -5C", 5'b11111);
        avail_cap = 16'd880; wait_n(2); check("R6 -5C 79.2%", 5'b01111);
        avail_cap = 16'd1000;
        temp_c = -8'sd15;  wait_n(2); check("R6 -15C", 5'b01111);
        temp_c = -8'sd20;  wait_n(2); check("R6 -20C", 5'b01111);
        temp_c = -8'sd21;  wait_n(2); check("R6 -21C", 5'b00111);

        // R7 NiMH derating
        chem_nimh = 1;
        temp_c = 8'sd10;   wait_n(2); check("R7 10C", 5'b11111);
        temp_c = 8'sd9;    wait_n(2); check("R7 9C", 5'b01111);
        temp_c = 8'sd0;    wait_n(2); check("R7 0C", 5'b01111);
        temp_c = -8'sd1;   wait_n(2); check("R7 -1C", 5'b00111);
        temp_c = -8'sd10;  wait_n(2); check("R7 -10C", 5'b00111);
        temp_c = -8'sd11;  blink_check("R7 -11C zero factor");
        chem_nimh = 0; temp_c = 8'sd25;

        // R3 low voltage at full capacity
        low_volt = 1; blink_check("R3 low voltage");
        low_volt = 0;

        // R10 registered output
        wait_n(2);
        avail_cap = 16'd500;
        #1 check("R10 before edge", 5'b11111);
        @(negedge clk); check("R10 after edge", 5'b00111);
        avail_cap = 16'd1000;

        // R5 flags off, R4 button window
        dsg_active = 0; wait_n(2); check("R5 idle", 5'd0);
        button_n = 0; wait_n(2); button_n = 1;
        wait_n(5);   check("R4 on after press", 5'b11111);
        wait_n(200); check("R4 still on", 5'b11111);
        wait_n(70);  check("R4 expired", 5'd0);
        button_n = 0; wait_n(2); button_n = 1;
        wait_n(200);
        button_n = 0; wait_n(2); button_n = 1;
        wait_n(200); check("R4 restarted", 5'b11111);
        wait_n(80);  check("R4 expired again", 5'd0);

        // R8 manual override while idle and while active
        ovr_ctrl = 6'b010101; wait_n(2); check("R8 idle", 5'b10101);
        chg_active = 1; ovr_ctrl = 6'b001010; wait_n(2); check("R8 active", 5'b01010);
        ovr_ctrl = 6'b100000; wait_n(2); check("R8 released", 5'b11111);

        // R9 calibration blanks everything
        cal_busy = 1; wait_n(2); check("R9 bar", 5'd0);
        ovr_ctrl = 6'b011111; wait_n(2); check("R9 manual", 5'd0);
        cal_busy = 0; wait_n(2); check("R9 released", 5'b11111);

        wait_n(4);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule